// File: doc/BRIEF.md
# Cascaded 32-Line Interrupt Aggregator

This block merges 32 peripheral interrupt lines and one bridge interrupt into a single request toward the processor. Four 8-line slave controllers each cover one group of eight global lines. Each slave sums its group into one pending flag. The flags from slaves 0 to 3 drive master inputs 1, 3, 4 and 5. Master input 0 is the bridge interrupt. Master inputs 2, 6 and 7 never request.

The master chooses a winner, and the block registers it as a 6-bit interrupt number. Numbers 0 to 31 are global lines, and 32 is the bridge. When the processor acknowledges, the block sets an in-service bit in the slave and another in the master. Software must then send two specific end-of-interrupt commands: one to the slave and one to the master.

A pair of trigger-control registers selects edge or level detection for the lines whose trigger mode can change. The remaining lines have a fixed trigger mode. All registers sit on a small byte-wide bus.

Top module: `cascade_irq_agg`

## Requirements
- R1: After reset, every slave mask reads 0xFF, both trigger-control registers read 0x00, and `int_req` is low.
- R2: A 1 in a slave mask bit blocks that line, and a 0 lets it request. A line whose mask bit is 1 is never presented.
- R3: Global line n belongs to slave n/8, bit n%8. `int_num` reports n for a line and 32 for the bridge.
- R4: Master input 0 (the bridge) has the highest priority, followed by master inputs 1, 3, 4 and 5, which are slaves 0 to 3. Within a slave, the lowest-numbered unmasked pending line wins.
- R5: A level-mode line requests only while its input is high. An edge-mode line latches a rising edge and stays pending until it is acknowledged. Lines 3, 6, 7, 8, 9 and 15 are always edge mode. Lines 0, 1, 2, 4, 5, 20 and 23 to 31 are always level mode.
- R6: Trigger-control register A (address 0xA) maps bits 0-4 to lines 10-14 and bits 5-7 to lines 16-18. Register B (address 0xB) maps bit 0 to line 19 and bits 1-2 to lines 21-22. Bits 3-7 of register B read 0. A 1 selects level mode.
- R7: An `int_ack` while `int_req` is high drops `int_req` on the next cycle. It also sets the in-service bit of the presented line and of its master input.
- R8: Writing 0xE0|k to a slave command port clears that slave's in-service bit k. Writing 0xE0|m to the master command port (address 0x0) clears master in-service bit m. While either bit is set, the line is not presented again.
- R9: A command write whose bits 7:5 are not 111 leaves every in-service bit unchanged.
- R10: Slave s has its command port at address 2+2s and its mask at address 3+2s. `bus_rdata` returns the addressed register one cycle after the address is applied, and unused addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_in | input | 32 | Global interrupt lines |
| bridge_irq | input | 1 | Bridge interrupt on master input 0, level |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 4 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| int_ack | input | 1 | Processor acknowledge of the presented number |
| int_req | output | 1 | Interrupt request to the processor |
| int_num | output | 6 | Presented number: 0-31 for a line, 32 for the bridge |

## Verification
A stuck in-service bit in either a slave or the master keeps a line silent after both end-of-interrupt writes. This shows up as a missing `int_req` within three cycles of the second write. A wrong slave-to-master input mapping, or a wrong trigger-register bit placement, changes which `int_num` wins, or whether a released line keeps requesting. Both show up in the presented number two cycles after the inputs change. A mask bit with the wrong polarity shows up as a reset readback other than 0xFF, or as a masked line being presented.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;
  localparam int LINES     = 8;
  localparam int NSLV      = 4;
  localparam int GLOBAL_N  = LINES * NSLV;
  localparam int IDX_W     = $clog2(LINES);
  localparam int NUM_W     = $clog2(GLOBAL_N) + 1;
  localparam logic [2:0] EOI_OP = 3'b111;
  // lines with a fixed level trigger; all other fixed lines are edge
  localparam logic [GLOBAL_N-1:0] FIXED_LEVEL = 32'hFF90_0037;

  function automatic logic [IDX_W-1:0] slv_to_master(input logic [1:0] s);
    case (s)
      2'd0:    return IDX_W'(1);
      2'd1:    return IDX_W'(3);
      2'd2:    return IDX_W'(4);
      default: return IDX_W'(5);
    endcase
  endfunction

  function automatic logic [1:0] master_to_slv(input logic [IDX_W-1:0] m);
    case (m)
      IDX_W'(3): return 2'd1;
      IDX_W'(4): return 2'd2;
      IDX_W'(5): return 2'd3;
      default:   return 2'd0;
    endcase
  endfunction

  function automatic logic [IDX_W-1:0] lowest_set(input logic [LINES-1:0] v);
    logic [IDX_W-1:0] r;
    r = '0;
    for (int i = LINES - 1; i >= 0; i--)
      if (v[i]) r = IDX_W'(i);
    return r;
  endfunction
endpackage

// File: rtl/irq_slave_unit.sv
module irq_slave_unit
  import irq_agg_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic [LINES-1:0] line_in,
  input  logic [LINES-1:0] level_mode,
  input  logic             mask_we,
  input  logic             eoi_we,
  input  logic [7:0]       wdata,
  input  logic             ack,
  input  logic [IDX_W-1:0] ack_line,
  output logic [LINES-1:0] mask_q,
  output logic             pend,
  output logic [IDX_W-1:0] win
);
  logic [LINES-1:0] prev_q, latch_q, isr_q, req, cand, ack_bit, eoi_bit;

  always_comb begin
    ack_bit = ack ? (LINES'(1) << ack_line) : '0;
    eoi_bit = (eoi_we && wdata[7:5] == EOI_OP) ? (LINES'(1) << wdata[IDX_W-1:0]) : '0;
    req     = (level_mode & line_in) | (~level_mode & latch_q);
    cand    = req & ~mask_q & ~isr_q;
    pend    = |cand;
    win     = lowest_set(cand);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q  <= '0;
      latch_q <= '0;
      isr_q   <= '0;
      mask_q  <= '1;
    end else begin
      prev_q  <= line_in;
      latch_q <= ((latch_q & ~ack_bit) | (line_in & ~prev_q)) & ~level_mode;
      isr_q   <= (isr_q | ack_bit) & ~eoi_bit;
      if (mask_we) mask_q <= wdata[LINES-1:0];
    end
  end
endmodule

// File: rtl/irq_master_unit.sv
module irq_master_unit
  import irq_agg_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic [LINES-1:0] req_in,
  input  logic             eoi_we,
  input  logic [7:0]       wdata,
  input  logic             ack,
  input  logic [IDX_W-1:0] ack_in,
  output logic             pend,
  output logic [IDX_W-1:0] win
);
  logic [LINES-1:0] isr_q, cand, ack_bit, eoi_bit;

  always_comb begin
    ack_bit = ack ? (LINES'(1) << ack_in) : '0;
    eoi_bit = (eoi_we && wdata[7:5] == EOI_OP) ? (LINES'(1) << wdata[IDX_W-1:0]) : '0;
    cand    = req_in & ~isr_q;
    pend    = |cand;
    win     = lowest_set(cand);
  end

  always_ff @(posedge clk) begin
    if (rst) isr_q <= '0;
    else     isr_q <= (isr_q | ack_bit) & ~eoi_bit;
  end
endmodule

// File: rtl/cascade_irq_agg.sv
module cascade_irq_agg
  import irq_agg_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [GLOBAL_N-1:0] irq_in,
  input  logic                bridge_irq,
  input  logic                bus_we,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic [7:0]          bus_wdata,
  output logic [7:0]          bus_rdata,
  input  logic                int_ack,
  output logic                int_req,
  output logic [NUM_W-1:0]    int_num
);
  localparam logic [ADDR_W-1:0] A_MCMD  = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_TRIGA = ADDR_W'(10);
  localparam logic [ADDR_W-1:0] A_TRIGB = ADDR_W'(11);

  logic [7:0]          trig_a_q;
  logic [2:0]          trig_b_q;
  logic [GLOBAL_N-1:0] level_vec, mask_all;
  logic [NSLV-1:0]     s_pend;
  logic [IDX_W-1:0]    s_win [NSLV];
  logic [LINES-1:0]    m_req;
  logic                m_pend, ack_go;
  logic [IDX_W-1:0]    m_win, m_ack_in;
  logic [1:0]          sel_slv;
  logic [7:0]          rd_mux;

  assign ack_go = int_ack && int_req;

  always_comb begin
    level_vec        = FIXED_LEVEL;
    level_vec[14:10] = trig_a_q[4:0];
    level_vec[18:16] = trig_a_q[7:5];
    level_vec[19]    = trig_b_q[0];
    level_vec[22:21] = trig_b_q[2:1];
  end

  for (genvar s = 0; s < NSLV; s++) begin : g_slv
    irq_slave_unit u_slv (
      .clk        (clk),
      .rst        (rst),
      .line_in    (irq_in[s*LINES +: LINES]),
      .level_mode (level_vec[s*LINES +: LINES]),
      .mask_we    (bus_we && bus_addr == ADDR_W'(3 + 2*s)),
      .eoi_we     (bus_we && bus_addr == ADDR_W'(2 + 2*s)),
      .wdata      (bus_wdata),
      .ack        (ack_go && !int_num[NUM_W-1] && int_num[NUM_W-2:IDX_W] == 2'(s)),
      .ack_line   (int_num[IDX_W-1:0]),
      .mask_q     (mask_all[s*LINES +: LINES]),
      .pend       (s_pend[s]),
      .win        (s_win[s])
    );
  end

  always_comb begin
    m_req    = '0;
    m_req[0] = bridge_irq;
    for (int s = 0; s < NSLV; s++)
      m_req[slv_to_master(2'(s))] = s_pend[s];
    m_ack_in = int_num[NUM_W-1] ? '0 : slv_to_master(int_num[NUM_W-2:IDX_W]);
    sel_slv  = master_to_slv(m_win);
  end

  irq_master_unit u_mst (
    .clk    (clk),
    .rst    (rst),
    .req_in (m_req),
    .eoi_we (bus_we && bus_addr == A_MCMD),
    .wdata  (bus_wdata),
    .ack    (ack_go),
    .ack_in (m_ack_in),
    .pend   (m_pend),
    .win    (m_win)
  );

  always_comb begin
    rd_mux = '0;
    for (int s = 0; s < NSLV; s++)
      if (bus_addr == ADDR_W'(3 + 2*s)) rd_mux = mask_all[s*LINES +: LINES];
    if (bus_addr == A_TRIGA) rd_mux = trig_a_q;
    if (bus_addr == A_TRIGB) rd_mux = {5'b0, trig_b_q};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      trig_a_q  <= '0;
      trig_b_q  <= '0;
      bus_rdata <= '0;
      int_req   <= 1'b0;
      int_num   <= '0;
    end else begin
      bus_rdata <= rd_mux;
      if (bus_we && bus_addr == A_TRIGA) trig_a_q <= bus_wdata;
      if (bus_we && bus_addr == A_TRIGB) trig_b_q <= bus_wdata[2:0];
      if (ack_go) begin
        int_req <= 1'b0;
      end else begin
        int_req <= m_pend;
        if (m_win == '0) int_num <= NUM_W'(GLOBAL_N);
        else             int_num <= {1'b0, sel_slv, s_win[sel_slv]};
      end
    end
  end
endmodule

// File: rtl/cascade_irq_agg_chk.sv
module cascade_irq_agg_chk
  import irq_agg_pkg::*;
(
  input logic                clk,
  input logic                rst,
  input logic [GLOBAL_N-1:0] irq_in,
  input logic                bridge_irq,
  input logic                int_ack,
  input logic                int_req,
  input logic [NUM_W-1:0]    int_num,
  input logic [GLOBAL_N-1:0] level_vec,
  input logic [GLOBAL_N-1:0] mask_all
);
  // R3: only 0..31 or the bridge code 32
  a_r3_num_range: assert property (@(posedge clk) disable iff (rst)
    int_req |-> (!int_num[NUM_W-1] || int_num == NUM_W'(GLOBAL_N)));

  // R2: a presented line had its mask bit clear
  a_r2_masked_silent: assert property (@(posedge clk) disable iff (rst)
    (int_req && !int_num[NUM_W-1]) |->
      ((($past(mask_all) >> int_num[NUM_W-2:0]) & GLOBAL_N'(1)) == '0));

  // R5: a presented level-mode line was high
  a_r5_level_held: assert property (@(posedge clk) disable iff (rst)
    (int_req && !int_num[NUM_W-1]) |->
      ((($past(level_vec & ~irq_in) >> int_num[NUM_W-2:0]) & GLOBAL_N'(1)) == '0));

  // R4: bridge code only when the bridge input requested
  a_r4_bridge_src: assert property (@(posedge clk) disable iff (rst)
    (int_req && int_num == NUM_W'(GLOBAL_N)) |-> $past(bridge_irq));

  // R7: acknowledge drops the request next cycle
  a_r7_ack_drop: assert property (@(posedge clk) disable iff (rst)
    (int_req && int_ack) |=> !int_req);
endmodule

bind cascade_irq_agg cascade_irq_agg_chk u_chk (
  .clk        (clk),
  .rst        (rst),
  .irq_in     (irq_in),
  .bridge_irq (bridge_irq),
  .int_ack    (int_ack),
  .int_req    (int_req),
  .int_num    (int_num),
  .level_vec  (level_vec),
  .mask_all   (mask_all)
);

// File: tb/cascade_irq_agg_bench.sv
module cascade_irq_agg_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] irq_in = '0;
  logic        bridge_irq = 1'b0;
  logic        bus_we = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [7:0]  bus_wdata = '0;
  logic [7:0]  bus_rdata;
  logic        int_ack = 1'b0;
  logic        int_req;
  logic [5:0]  int_num;
  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  cascade_irq_agg u_cascade_irq_agg (
    .clk(clk), .rst(rst), .irq_in(irq_in), .bridge_irq(bridge_irq),
    .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .int_ack(int_ack), .int_req(int_req),
    .int_num(int_num)
  );

  // {irq pattern, bridge, expected req, expected number}
  localparam logic [39:0] VEC [10] = '{
    {32'h0000_0000, 1'b0, 1'b0, 6'd0},
    {32'h0000_0020, 1'b0, 1'b1, 6'd5},
    {32'h0000_0022, 1'b0, 1'b1, 6'd1},
    {32'h0100_0000, 1'b0, 1'b1, 6'd24},
    {32'h0101_0000, 1'b0, 1'b1, 6'd16},
    {32'h0080_1000, 1'b0, 1'b1, 6'd12},
    {32'h0000_0001, 1'b1, 1'b1, 6'd32},
    {32'h8000_0000, 1'b0, 1'b1, 6'd31},
    {32'h8010_0000, 1'b0, 1'b1, 6'd20},
    {32'h0000_0404, 1'b0, 1'b1, 6'd2}
  };

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] d);
    bus_addr = a;
    @(negedge clk);
    d = bus_rdata;
  endtask

  task automatic pulse(input int line);
    irq_in[line] = 1'b1;
    @(negedge clk);
    irq_in[line] = 1'b0;
  endtask

  task automatic ack;
    int_ack = 1'b1;
    @(negedge clk);
    int_ack = 1'b0;
  endtask

  task automatic expect_irq(input string tag, input int req, input int num);
    check(tag, int_req, req);
    if (req != 0) check(tag, int_num, num);
  endtask

  initial begin
    for (int c = 0; c < 100000; c++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    wait_n(3);
    rst = 1'b0;
    @(negedge clk);
    // R1 / R10: reset values through the register map
    for (int s = 0; s < 4; s++) begin
      rd(4'(3 + 2*s), d);
      check("R1 mask reset", d, 8'hFF);
    end
    rd(4'hA, d); check("R1 trigA reset", d, 0);
    rd(4'hB, d); check("R1 trigB reset", d, 0);
    rd(4'hC, d); check("R10 unused addr", d, 0);
    check("R1 req reset", int_req, 0);
    // R2: all masked, lines high give nothing
    irq_in = 32'h8000_0001;
    wait_n(3);
    check("R2 all masked", int_req, 0);
    irq_in = '0;
    // R6: trigger register widths
    wr(4'hA, 8'hFF);
    wr(4'hB, 8'hFF);
    rd(4'hB, d); check("R6 trigB upper bits zero", d, 8'h07);
    rd(4'hA, d); check("R6 trigA readback", d, 8'hFF);
    for (int s = 0; s < 4; s++) wr(4'(3 + 2*s), 8'h00);
    rd(4'h9, d); check("R10 slave3 mask readback", d, 0);
    // R3 / R4: priority and numbering table
    foreach (VEC[i]) begin
      irq_in = VEC[i][39:8];
      bridge_irq = VEC[i][7];
      wait_n(3);
      expect_irq($sformatf("R3 R4 vector %0d", i), VEC[i][6], VEC[i][5:0]);
    end
    irq_in = '0; bridge_irq = 1'b0;
    wait_n(3);
    // R2: masked line 1 loses to line 4
    wr(4'h3, 8'h02);
    irq_in = 32'h0000_0012;
    wait_n(3);
    expect_irq("R2 masked line skipped", 1, 4);
    irq_in = '0;
    wr(4'h3, 8'h00);
    // R5: level line drops with its input
    irq_in[5] = 1'b1;
    wait_n(3);
    expect_irq("R5 level present", 1, 5);
    irq_in[5] = 1'b0;
    wait_n(3);
    check("R5 level released", int_req, 0);
    // R7 / R8 / R9: level line 0 held high
    irq_in[0] = 1'b1;
    wait_n(3);
    expect_irq("R7 before ack", 1, 0);
    ack();
    check("R7 req drops after ack", int_req, 0);
    wait_n(3);
    check("R7 in service blocks", int_req, 0);
    wr(4'h2, 8'h20);
    wr(4'h0, 8'h21);
    wait_n(3);
    check("R9 non-specific command ignored", int_req, 0);
    wr(4'h2, 8'hE0);
    wait_n(3);
    check("R8 master still in service", int_req, 0);
    wr(4'h0, 8'hE1);
    wait_n(3);
    expect_irq("R8 redelivered after both EOIs", 1, 0);
    irq_in[0] = 1'b0;
    ack();
    wr(4'h2, 8'hE0);
    wr(4'h0, 8'hE1);
    wait_n(3);
    check("R8 idle after cleanup", int_req, 0);
    // R5: fixed edge line 3 latches a pulse
    pulse(3);
    wait_n(3);
    expect_irq("R5 edge latched", 1, 3);
    ack();
    wr(4'h2, 8'hE3);
    wr(4'h0, 8'hE1);
    wait_n(3);
    check("R5 latch cleared by ack", int_req, 0);
    // R6: line 12 switched to edge by clearing trigA bit 2
    wr(4'hA, 8'hFB);
    pulse(12);
    wait_n(3);
    expect_irq("R6 line 12 in edge mode", 1, 12);
    ack();
    wr(4'h4, 8'hE4);
    wr(4'h0, 8'hE3);
    wait_n(3);
    check("R6 line 12 done", int_req, 0);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule